// File: doc/BRIEF.md
# Misaligned Access Transfer Splitter

This block takes one operand access from an internal requester and turns it into a series of naturally aligned bus sub-transfers. The operand may be a byte, a word (16 bits) or a longword (32 bits), and it may start at any byte address. The target port may be 8, 16 or 32 bits wide. Each sub-transfer carries its own address and a 2-bit code for the size of that piece. On a write it also carries the matching slice of the write data. On a read, the bytes returned by each sub-transfer are put back into the operand in order.

The requester raises `reqValid` for one cycle while the block is idle. The block then works through the sub-transfers on a valid/acknowledge handshake toward a bus master. One cycle after the last acknowledge, it pulses `reqDone`. During that cycle the assembled read operand is on `reqRdata`. Byte order is big-endian: the lowest address holds the most significant byte of the operand.

Top module: `xfer_splitter`

## Requirements
- R1: While reset is held and right after it, `subValid` and `reqDone` are low.
- R2: A request is accepted only when the block is idle. `reqSize` encodes 0 = byte, 1 = word, 2 or 3 = longword. `reqPort` encodes 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. The operand sits right-justified in `reqWdata` and `reqRdata`.
- R3: Each piece takes the largest size among 4, 2 and 1 bytes that meets three limits. The current address must be a multiple of that size. The size must not exceed the bytes still to move. The size must not exceed the port width.
- R4: `subTsiz` is 2'b01 for a byte piece, 2'b10 for a word piece and 2'b00 for a longword piece. The value 2'b11 never appears.
- R5: The first sub-transfer address equals `reqAddr`. Each following address is the previous one plus the previous piece size in bytes. For example, a longword at offset 1 on a 32-bit port gives a byte at 1, a word at 2 and a byte at 4.
- R6: On a write, `subWdata` carries the piece right-justified. The operand byte meant for the lowest address sits in the most significant position of the piece. Unused upper bits are zero.
- R7: On a read, the piece is taken right-justified from `subRdata`. Pieces are concatenated in address order, so the first piece ends up most significant in `reqRdata`.
- R8: `reqDone` is high for exactly one cycle. That cycle is the one right after the cycle in which the last sub-transfer was acknowledged.
- R9: An access whose address is a multiple of its size, and whose size is no wider than the port, yields exactly one sub-transfer.
- R10: While `subValid` is high and `subAck` is low, `subValid`, `subAddr`, `subTsiz` and `subWdata` hold their values.
- R11: A `reqValid` pulse that arrives while an access is in progress is ignored and causes no later sub-transfer.
- R12: `subWrite` equals the direction latched from `reqWrite` for every sub-transfer of the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Start an access (sampled when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Byte address of the operand |
| reqSize | input | 2 | Operand size code |
| reqPort | input | 2 | Target port width code |
| reqWdata | input | 32 | Write operand, right-justified |
| reqDone | output | 1 | One-cycle completion pulse |
| reqRdata | output | 32 | Assembled read operand, valid with reqDone |
| subValid | output | 1 | Sub-transfer request |
| subAck | input | 1 | Sub-transfer acknowledge |
| subAddr | output | ADDR_W | Sub-transfer byte address |
| subTsiz | output | 2 | Sub-transfer size code |
| subWrite | output | 1 | Sub-transfer direction |
| subWdata | output | 32 | Sub-transfer write data, right-justified |
| subRdata | input | 32 | Sub-transfer read data, right-justified |

## Verification
The bench targets three kinds of corner case: odd start offsets, operands that cross a 4-byte boundary, and ports narrower than the operand.

If the piece rule is wrong, a word is issued at an odd address, or a longword piece appears on a 16-bit port, and the bench flags a wrong `subTsiz` or `subAddr`. If the byte order is reversed or misplaced, write slices come out swapped and read operands are reassembled in the wrong order. If the completion timing is off by one, `reqDone` arrives with the last acknowledge or a cycle late.

Acknowledges are held back for random numbers of cycles to show that outputs stay stable. Stray request pulses are sent during busy accesses to show they are not queued.

// File: rtl/xfer_splitter_pkg.sv
package xfer_splitter_pkg;
  localparam int OP_BYTES = 4;
  localparam int OP_W = OP_BYTES * 8;

  localparam logic [1:0] TSIZ_BYTE = 2'b01;
  localparam logic [1:0] TSIZ_WORD = 2'b10;
  localparam logic [1:0] TSIZ_LONG = 2'b00;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } stateT;

  typedef struct packed {
    logic load;
    logic step;
  } strobeT;

  function automatic logic [2:0] codeToBytes(input logic [1:0] code);
    case (code)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction
endpackage

// File: rtl/xfer_splitter_ctrl.sv
module xfer_splitter_ctrl
  import xfer_splitter_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   subAck,
  input  logic   lastPiece,
  output strobeT strobe,
  output logic   subValid,
  output logic   reqDone
);
  stateT state, stateNext;

  always_comb begin
    stateNext   = state;
    strobe.load = 1'b0;
    strobe.step = 1'b0;
    case (state)
      ST_IDLE: if (reqValid) begin
        strobe.load = 1'b1;
        stateNext   = ST_RUN;
      end
      ST_RUN: if (subAck) begin
        strobe.step = 1'b1;
        if (lastPiece) stateNext = ST_DONE;
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign subValid = (state == ST_RUN);
  assign reqDone  = (state == ST_DONE);
endmodule

// File: rtl/xfer_splitter_dp.sv
module xfer_splitter_dp
  import xfer_splitter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqPort,
  input  logic [OP_W-1:0]   reqWdata,
  input  logic [OP_W-1:0]   subRdata,
  output logic              lastPiece,
  output logic [ADDR_W-1:0] subAddr,
  output logic [1:0]        subTsiz,
  output logic              subWrite,
  output logic [OP_W-1:0]   subWdata,
  output logic [OP_W-1:0]   reqRdata
);
  logic [ADDR_W-1:0] curAddr;
  logic [OP_W-1:0]   opLeft;
  logic [OP_W-1:0]   accLeft;
  logic [2:0]        consumed;
  logic [2:0]        remain;
  logic [2:0]        portBytes;
  logic              writeReg;

  logic [2:0]        pieceBytes;
  logic [2:0]        pieceGap;
  logic [2:0]        loadGap;
  logic [OP_W-1:0]   pieceMask;
  logic [OP_W-1:0]   opShifted;
  logic [OP_W-1:0]   rdPlaced;

  always_comb begin
    if (curAddr[1:0] == 2'b00 && remain >= 3'd4 && portBytes >= 3'd4)
      pieceBytes = 3'd4;
    else if (!curAddr[0] && remain >= 3'd2 && portBytes >= 3'd2)
      pieceBytes = 3'd2;
    else
      pieceBytes = 3'd1;
  end

  always_comb begin
    case (pieceBytes)
      3'd4:    begin subTsiz = TSIZ_LONG; pieceMask = {OP_W{1'b1}}; end
      3'd2:    begin subTsiz = TSIZ_WORD; pieceMask = {{(OP_W-16){1'b0}}, 16'hFFFF}; end
      default: begin subTsiz = TSIZ_BYTE; pieceMask = {{(OP_W-8){1'b0}}, 8'hFF}; end
    endcase
  end

  assign pieceGap  = 3'd4 - pieceBytes;
  assign loadGap   = 3'd4 - codeToBytes(reqSize);
  assign lastPiece = (remain == pieceBytes);
  assign opShifted = opLeft << {consumed, 3'b000};
  assign subWdata  = opShifted >> {pieceGap, 3'b000};
  assign rdPlaced  = ((subRdata & pieceMask) << {pieceGap, 3'b000}) >> {consumed, 3'b000};
  assign subAddr   = curAddr;
  assign subWrite  = writeReg;
  assign reqRdata  = accLeft >> {3'(3'd4 - consumed), 3'b000};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      opLeft    <= '0;
      accLeft   <= '0;
      consumed  <= '0;
      remain    <= '0;
      portBytes <= 3'd4;
      writeReg  <= 1'b0;
    end else if (strobe.load) begin
      curAddr   <= reqAddr;
      opLeft    <= reqWdata << {loadGap, 3'b000};
      accLeft   <= '0;
      consumed  <= '0;
      remain    <= codeToBytes(reqSize);
      portBytes <= codeToBytes(reqPort);
      writeReg  <= reqWrite;
    end else if (strobe.step) begin
      curAddr  <= curAddr + ADDR_W'(pieceBytes);
      accLeft  <= accLeft | rdPlaced;
      consumed <= consumed + pieceBytes;
      remain   <= remain - pieceBytes;
    end
  end
endmodule

// File: rtl/xfer_splitter.sv
module xfer_splitter
  import xfer_splitter_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqSize,
  input  logic [1:0]        reqPort,
  input  logic [31:0]       reqWdata,
  output logic              reqDone,
  output logic [31:0]       reqRdata,
  output logic              subValid,
  input  logic              subAck,
  output logic [ADDR_W-1:0] subAddr,
  output logic [1:0]        subTsiz,
  output logic              subWrite,
  output logic [31:0]       subWdata,
  input  logic [31:0]       subRdata
);
  strobeT strobe;
  logic   lastPiece;

  xfer_splitter_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .subAck(subAck),
    .lastPiece(lastPiece), .strobe(strobe), .subValid(subValid), .reqDone(reqDone)
  );

  xfer_splitter_dp #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqPort(reqPort), .reqWdata(reqWdata),
    .subRdata(subRdata), .lastPiece(lastPiece), .subAddr(subAddr), .subTsiz(subTsiz),
    .subWrite(subWrite), .subWdata(subWdata), .reqRdata(reqRdata)
  );
endmodule

// File: rtl/xfer_splitter_chk.sv
module xfer_splitter_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              subValid,
  input logic              subAck,
  input logic [ADDR_W-1:0] subAddr,
  input logic [1:0]        subTsiz,
  input logic [31:0]       subWdata,
  input logic              reqDone
);
  a_r4_no_reserved_code: assert property (@(posedge clk) disable iff (!rstN)
    subValid |-> subTsiz != 2'b11);

  a_r3_long_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subTsiz == 2'b00) |-> subAddr[1:0] == 2'b00);

  a_r3_word_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subTsiz == 2'b10) |-> !subAddr[0]);

  a_r10_hold_until_ack: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !subAck) |=> subValid && $stable(subAddr) && $stable(subTsiz) && $stable(subWdata));

  a_r8_done_single: assert property (@(posedge clk) disable iff (!rstN)
    reqDone |=> !reqDone);

  a_r8_done_after_ack: assert property (@(posedge clk) disable iff (!rstN)
    $rose(reqDone) |-> $past(subValid && subAck));

  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    !(reqDone && subValid));
endmodule

bind xfer_splitter xfer_splitter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .subValid(subValid), .subAck(subAck),
  .subAddr(subAddr), .subTsiz(subTsiz), .subWdata(subWdata), .reqDone(reqDone)
);

// File: tb/sim_xfer_splitter.sv
module sim_xfer_splitter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqSize = '0;
  logic [1:0]  reqPort = '0;
  logic [31:0] reqWdata = '0;
  logic        reqDone;
  logic [31:0] reqRdata;
  logic        subValid;
  logic        subAck = 1'b0;
  logic [31:0] subAddr;
  logic [1:0]  subTsiz;
  logic        subWrite;
  logic [31:0] subWdata;
  logic [31:0] subRdata = '0;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;

  xfer_splitter #(.ADDR_W(32)) u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqPort(reqPort), .reqWdata(reqWdata),
    .reqDone(reqDone), .reqRdata(reqRdata), .subValid(subValid), .subAck(subAck),
    .subAddr(subAddr), .subTsiz(subTsiz), .subWrite(subWrite), .subWdata(subWdata),
    .subRdata(subRdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // R3: the largest aligned piece within remaining bytes and port width
  function automatic int pieceOf(input logic [31:0] a, input int rem, input int pb);
    if (a[1:0] == 2'b00 && rem >= 4 && pb >= 4) return 4;
    if (!a[0] && rem >= 2 && pb >= 2) return 2;
    return 1;
  endfunction

  // R4: size code per piece
  function automatic logic [1:0] codeOf(input int m);
    return (m == 4) ? 2'b00 : (m == 2) ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [31:0] maskOf(input int m);
    return (m == 4) ? 32'hFFFF_FFFF : (m == 2) ? 32'h0000_FFFF : 32'h0000_00FF;
  endfunction

  task automatic doAccess(input logic [31:0] addr, input int sz, input int port,
                          input logic wr, input logic [31:0] wd, input int maxDly, input bit poke);
    int n = 1 << sz;
    int pb = 1 << port;
    int rem = n;
    int cnt = 0;
    logic [31:0] a = addr;
    logic [31:0] expRd = '0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = addr; reqSize = 2'(sz); reqPort = 2'(port);
    reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (rem > 0) begin
      int m = pieceOf(a, rem, pb);
      int d = (maxDly == 0) ? 0 : int'($urandom_range(maxDly, 0));
      logic [31:0] rd;
      for (int i = 0; i < d; i++) begin
        check(subValid === 1'b1, "R10 subValid held while waiting", 32'(subValid), 32'd1);
        @(negedge clk);
      end
      check(subValid === 1'b1, "R5 subValid asserted", 32'(subValid), 32'd1);
      check(subAddr === a, "R5 sub-transfer address", subAddr, a);
      check(subTsiz === codeOf(m), "R3/R4 piece size code", 32'(subTsiz), 32'(codeOf(m)));
      check(subWrite === wr, "R12 direction", 32'(subWrite), 32'(wr));
      if (wr) begin
        logic [31:0] ew = (wd >> (8 * (rem - m))) & maskOf(m);
        check(subWdata === ew, "R6 write slice", subWdata, ew);
      end
      rd = $urandom;
      subAck = 1'b1; subRdata = rd;
      if (poke && cnt == 0) begin
        reqValid = 1'b1; reqAddr = ~addr; reqSize = 2'd0; reqPort = 2'd0; reqWrite = ~wr;
      end
      expRd = (expRd << (8 * m)) | (rd & maskOf(m));
      @(negedge clk);
      subAck = 1'b0; reqValid = 1'b0;
      rem -= m; a += 32'(m); cnt++;
    end
    check(reqDone === 1'b1, "R8 done one cycle after last ack", 32'(reqDone), 32'd1);
    check(subValid === 1'b0, "R8 no request with done", 32'(subValid), 32'd0);
    if (!wr) check(reqRdata === expRd, "R7 read assembly", reqRdata, expRd);
    if ((addr % n) == 0 && n <= pb)
      check(cnt == 1, "R9 aligned fitting access is one piece", 32'(cnt), 32'd1);
    @(negedge clk);
    check(reqDone === 1'b0, "R8 done single cycle", 32'(reqDone), 32'd0);
    check(subValid === 1'b0, "R11 ignored request left no transfer", 32'(subValid), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog R8 actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(subValid === 1'b0, "R1 subValid in reset", 32'(subValid), 32'd0);
    check(reqDone === 1'b0, "R1 reqDone in reset", 32'(reqDone), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(subValid === 1'b0, "R1 subValid after reset", 32'(subValid), 32'd0);
    check(reqDone === 1'b0, "R1 reqDone after reset", 32'(reqDone), 32'd0);

    // directed corners (R2 encodings, R5 odd-offset longword)
    doAccess(32'h0000_1001, 2, 2, 1'b1, 32'hA1B2C3D4, 0, 1'b0);
    doAccess(32'h0000_1001, 2, 2, 1'b0, 32'h0,        2, 1'b0);
    doAccess(32'h0000_2000, 2, 2, 1'b1, 32'h11223344, 0, 1'b1);
    doAccess(32'h0000_2000, 2, 0, 1'b0, 32'h0,        1, 1'b0);
    doAccess(32'h0000_3003, 1, 1, 1'b1, 32'h0000BEEF, 0, 1'b0);
    doAccess(32'h0000_3002, 2, 1, 1'b0, 32'h0,        3, 1'b1);
    doAccess(32'h0000_4007, 0, 2, 1'b1, 32'h0000005A, 0, 1'b0);
    doAccess(32'h0000_5003, 2, 2, 1'b0, 32'h0,        0, 1'b0);

    for (int k = 0; k < 400; k++) begin
      doAccess($urandom, int'($urandom_range(2, 0)), int'($urandom_range(2, 0)),
               1'($urandom), $urandom, int'($urandom_range(2, 0)), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end
endmodule